// File: doc/BRIEF.md
# Clock Output Gating Controller

This block sits between a bank of free-running divided clocks and the output pins of a clock generator. It turns each source clock into a set of individually switchable output clocks: seven PCI clocks, three PCI clocks that may be exempt from PCI stop, two 48 MHz clocks, six 66 MHz-class clocks and three differential CPU pairs. Each output has its own enable bit. Three active-low control inputs can freeze groups of outputs: a PCI stop, a CPU stop and a power-down.

Everything runs on one fast master clock. The divided source clocks arrive as signals that are synchronous to that clock. The three stop inputs are asynchronous, so they pass through a synchronizer. Each output keeps a gate flop that may change only during one phase of its source. A single-ended output therefore always parks low, and a differential pair always parks with its true leg high and its complement leg low. No pulse is ever shortened. The enable bits come from a register file outside the block and are assumed to be synchronous to the master clock.

Top module: `clk_out_gate`

## Requirements
- R1: A single-ended output whose enable bit is 0 settles at logic low and stays there.
- R2: A stopped or disabled CPU pair settles with the true output at 1 and the complement output at 0. The two legs are never 1 at the same time.
- R3: While `pci_stop_n` is 0, all seven `pci_clk` outputs park low. The 48 MHz, 66 MHz and CPU outputs keep running.
- R4: Bit i of `pcif_stoppable` controls `pcif_clk[i]` during PCI stop. When the bit is 0 the output keeps running while `pci_stop_n` is 0. When the bit is 1 the output parks low with the PCI clocks.
- R5: While `cpu_stop_n` is 0, every CPU pair parks as in R2. All other outputs keep running.
- R6: While `pd_n` is 0, every output parks: single-ended outputs low, CPU pairs true high and complement low.
- R7: On any change of enable or stop, no output high or low time is shorter than half the period of its source clock.
- R8: When a stop or disable ends, a parked output restarts cleanly. A single-ended output restarts with a complete high phase after the low phase. A CPU pair restarts with the true leg falling together with its source.
- R9: While `rst` is 1, every output is held at its parked level.
- R10: A running output follows its source with exactly one master-clock cycle of delay. A CPU complement leg is the inverse of the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pci | input | 1 | 33 MHz source for the PCI and exempt PCI outputs |
| src_48 | input | 1 | 48 MHz source |
| src_66 | input | 1 | 66 MHz source |
| src_cpu | input | 1 | CPU source |
| pd_n | input | 1 | Power-down, active low, asynchronous |
| pci_stop_n | input | 1 | PCI stop, active low, asynchronous |
| cpu_stop_n | input | 1 | CPU stop, active low, asynchronous |
| en_pci | input | N_PCI | Per-output enable of the PCI clocks |
| en_pcif | input | N_PCIF | Per-output enable of the exempt PCI clocks |
| pcif_stoppable | input | N_PCIF | 1 = exempt PCI clock obeys PCI stop |
| en_48 | input | N_48 | Per-output enable of the 48 MHz clocks |
| en_66 | input | N_66 | Per-output enable of the 66 MHz clocks |
| en_cpu | input | N_CPU | Per-pair enable of the CPU clocks |
| pci_clk | output | N_PCI | Gated PCI clocks |
| pcif_clk | output | N_PCIF | Gated exempt PCI clocks |
| clk48 | output | N_48 | Gated 48 MHz clocks |
| clk66 | output | N_66 | Gated 66 MHz clocks |
| cpu_t | output | N_CPU | CPU pair true legs |
| cpu_c | output | N_CPU | CPU pair complement legs |

## Verification
The bench tracks the run length of every output and flags any high or low time shorter than half the source period. That check runs under directed changes and under random enable and stop patterns. A design that opened or closed the gate in the wrong source phase would show a runt pulse there. A pair gated during its low phase would show a shortened low phase on the true leg. Directed phases check each parked level, per output and per group, and the exemption bits for the exempt PCI clocks. Swapping the meaning of an exemption bit, parking a pair at the wrong polarity or letting CPU stop reach the PCI group each shows up as a wrong static level or a missing toggle. A one-cycle sample of every running output against its source catches any extra or missing pipeline stage.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int unsigned DEF_N_PCI  = 7;
  localparam int unsigned DEF_N_PCIF = 3;
  localparam int unsigned DEF_N_48   = 2;
  localparam int unsigned DEF_N_66   = 6;
  localparam int unsigned DEF_N_CPU  = 3;
  localparam int unsigned DEF_SYNC   = 2;

  // synchronized run permissions (1 = allowed to run)
  typedef struct packed {
    logic pwr;
    logic pci;
    logic cpu;
  } run_t;
endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/clkgate_se.sv
module clkgate_se (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic want_i,
  output logic out_o
);
  logic gate_q;
  logic out_q;

  // gate may only move while the source is low
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (!src_i) gate_q <= want_i;
      out_q <= src_i & gate_q;
    end
  end

  assign out_o = out_q;

  assert_park_low_R1: assert property (@(posedge clk) disable iff (rst)
    (!want_i && !src_i) ##1 (!want_i) |=> !out_q);

  // output only falls when its source fell (no runt high pulse)
  assert_fall_with_src_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(out_q) |-> !$past(src_i));
endmodule

// File: rtl/clkgate_diff.sv
module clkgate_diff (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic want_i,
  output logic out_t,
  output logic out_c
);
  logic gate_q;
  logic t_q;
  logic c_q;

  // gate may only move while the source is high (true leg already high)
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      t_q    <= 1'b1;
      c_q    <= 1'b0;
    end else begin
      if (src_i) gate_q <= want_i;
      t_q <= gate_q ? src_i : 1'b1;
      c_q <= gate_q & ~src_i;
    end
  end

  assign out_t = t_q;
  assign out_c = c_q;

  assert_pair_park_R2: assert property (@(posedge clk) disable iff (rst)
    (!want_i && src_i) ##1 (!want_i) |=> (t_q && !c_q));

  assert_pair_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(t_q && c_q));

  // true leg only rises when its source rose or it parks (never mid low phase)
  assert_true_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(t_q) |-> $past(src_i));
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate
  import clkgate_pkg::*;
#(
  parameter int unsigned N_PCI  = DEF_N_PCI,
  parameter int unsigned N_PCIF = DEF_N_PCIF,
  parameter int unsigned N_48   = DEF_N_48,
  parameter int unsigned N_66   = DEF_N_66,
  parameter int unsigned N_CPU  = DEF_N_CPU,
  parameter int unsigned SYNC   = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_pci,
  input  logic              src_48,
  input  logic              src_66,
  input  logic              src_cpu,
  input  logic              pd_n,
  input  logic              pci_stop_n,
  input  logic              cpu_stop_n,
  input  logic [N_PCI-1:0]  en_pci,
  input  logic [N_PCIF-1:0] en_pcif,
  input  logic [N_PCIF-1:0] pcif_stoppable,
  input  logic [N_48-1:0]   en_48,
  input  logic [N_66-1:0]   en_66,
  input  logic [N_CPU-1:0]  en_cpu,
  output logic [N_PCI-1:0]  pci_clk,
  output logic [N_PCIF-1:0] pcif_clk,
  output logic [N_48-1:0]   clk48,
  output logic [N_66-1:0]   clk66,
  output logic [N_CPU-1:0]  cpu_t,
  output logic [N_CPU-1:0]  cpu_c
);
  localparam int unsigned RUN_W = $bits(run_t);

  run_t run;
  logic [RUN_W-1:0] run_raw;

  clkgate_sync #(.W(RUN_W), .STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({pd_n, pci_stop_n, cpu_stop_n}),
    .q_o (run_raw)
  );
  assign run = run_t'(run_raw);

  logic [N_PCI-1:0]  want_pci;
  logic [N_PCIF-1:0] want_pcif;
  logic [N_48-1:0]   want_48;
  logic [N_66-1:0]   want_66;
  logic [N_CPU-1:0]  want_cpu;

  always_comb begin
    want_pci  = en_pci & {N_PCI{run.pwr & run.pci}};
    want_pcif = en_pcif & {N_PCIF{run.pwr}} & (~pcif_stoppable | {N_PCIF{run.pci}});
    want_48   = en_48 & {N_48{run.pwr}};
    want_66   = en_66 & {N_66{run.pwr}};
    want_cpu  = en_cpu & {N_CPU{run.pwr & run.cpu}};
  end

  generate
    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
      clkgate_se u_cell (.clk(clk), .rst(rst), .src_i(src_pci),
                         .want_i(want_pci[i]), .out_o(pci_clk[i]));
    end
    for (genvar i = 0; i < N_PCIF; i++) begin : g_pcif
      clkgate_se u_cell (.clk(clk), .rst(rst), .src_i(src_pci),
                         .want_i(want_pcif[i]), .out_o(pcif_clk[i]));
    end
    for (genvar i = 0; i < N_48; i++) begin : g_48
      clkgate_se u_cell (.clk(clk), .rst(rst), .src_i(src_48),
                         .want_i(want_48[i]), .out_o(clk48[i]));
    end
    for (genvar i = 0; i < N_66; i++) begin : g_66
      clkgate_se u_cell (.clk(clk), .rst(rst), .src_i(src_66),
                         .want_i(want_66[i]), .out_o(clk66[i]));
    end
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
      clkgate_diff u_cell (.clk(clk), .rst(rst), .src_i(src_cpu),
                           .want_i(want_cpu[i]), .out_t(cpu_t[i]), .out_c(cpu_c[i]));
    end
  endgenerate

  // power-down held for the whole synchronizer depth and beyond keeps PCI outputs low
  assert_pd_pci_low_R6: assert property (@(posedge clk) disable iff (rst)
    (!run.pwr && !src_pci) ##1 (!run.pwr) |=> (pci_clk == '0));
endmodule

// File: tb/clk_out_gate_tb.sv
module clk_out_gate_tb;
  localparam int NO = 24; // 7 pci, 3 pcif, 2 x48, 6 x66, 3 cpu_t, 3 cpu_c

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_pci = 0, src_48 = 0, src_66 = 0, src_cpu = 0;
  logic pd_n = 1, pci_stop_n = 1, cpu_stop_n = 1;
  logic [6:0] en_pci = '1;
  logic [2:0] en_pcif = '1, pcif_stoppable = '0;
  logic [1:0] en_48 = '1;
  logic [5:0] en_66 = '1;
  logic [2:0] en_cpu = '1;
  logic [6:0] pci_clk;
  logic [2:0] pcif_clk;
  logic [1:0] clk48;
  logic [5:0] clk66;
  logic [2:0] cpu_t, cpu_c;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_out_gate u_dut (
    .clk(clk), .rst(rst), .src_pci(src_pci), .src_48(src_48), .src_66(src_66),
    .src_cpu(src_cpu), .pd_n(pd_n), .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n),
    .en_pci(en_pci), .en_pcif(en_pcif), .pcif_stoppable(pcif_stoppable),
    .en_48(en_48), .en_66(en_66), .en_cpu(en_cpu), .pci_clk(pci_clk),
    .pcif_clk(pcif_clk), .clk48(clk48), .clk66(clk66), .cpu_t(cpu_t), .cpu_c(cpu_c));

  // free-running sources, changed away from the active edge
  int unsigned tick = 0;
  always @(negedge clk) begin
    tick <= tick + 1;
    src_pci <= ((tick + 1) % 8) >= 4;
    src_48  <= ((tick + 1) % 6) >= 3;
    src_66  <= ((tick + 1) % 4) >= 2;
    src_cpu <= ((tick + 1) % 2) == 1;
  end

  logic [NO-1:0] allout;
  assign allout = {cpu_c, cpu_t, clk66, clk48, pcif_clk, pci_clk};

  function automatic int half_of(int i);
    if (i < 10) return 4;
    if (i < 12) return 3;
    if (i < 18) return 2;
    return 1;
  endfunction

  function automatic logic src_of(int i);
    if (i < 10) return src_pci;
    if (i < 12) return src_48;
    if (i < 18) return src_66;
    if (i < 21) return src_cpu;
    return ~src_cpu;
  endfunction

  function automatic logic park_of(int i);
    return (i >= 18 && i < 21);
  endfunction

  task automatic sample();
    @(posedge clk);
    #2;
  endtask

  // scoreboard
  typedef struct {
    int    idx;
    bit    running;
    string req;
  } item_t;
  item_t q[$];
  bit busy = 0;

  initial begin : monitor
    forever begin
      item_t it;
      int bad;
      int toggles;
      logic prev;
      logic expv;
      wait (q.size() > 0);
      busy = 1;
      it = q.pop_front();
      bad = 0; toggles = 0; prev = 1'bx; expv = 1'b0;
      for (int k = 0; k < 16; k++) begin
        sample();
        // R10: running output equals its source one cycle later; parked holds level
        expv = it.running ? src_of(it.idx) : park_of(it.idx);
        if (allout[it.idx] !== expv) bad++;
        if (k > 0 && allout[it.idx] !== prev) toggles++;
        prev = allout[it.idx];
      end
      checks++;
      if (bad != 0 || (it.running && toggles == 0) || (!it.running && toggles != 0)) begin
        errors++;
        $display("FAIL %s out%0d running=%0d: mismatches %0d toggles %0d (expected 0 mismatches, %s)",
                 it.req, it.idx, it.running, bad, toggles, it.running ? "toggling" : "static");
      end
      busy = 0;
    end
  end

  task automatic expect_all(input logic [NO-1:0] run_mask, input string req);
    for (int i = 0; i < NO; i++) begin
      item_t it;
      it.idx = i; it.running = run_mask[i]; it.req = req;
      q.push_back(it);
    end
    wait (q.size() == 0 && !busy);
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  // R7 R8: run-length monitor over every output
  int  runlen [NO];
  bit  seen [NO];
  logic lastv [NO];
  initial begin : pulse_mon
    forever begin
      sample();
      for (int i = 0; i < NO; i++) begin
        if (rst) begin
          seen[i] = 0; runlen[i] = 0; lastv[i] = allout[i];
        end else if (allout[i] !== lastv[i]) begin
          if (seen[i]) begin
            checks++;
            if (runlen[i] < half_of(i)) begin
              errors++;
              $display("FAIL R7 out%0d pulse of %0d cycles, expected at least %0d",
                       i, runlen[i], half_of(i));
            end
          end
          seen[i] = 1; runlen[i] = 1; lastv[i] = allout[i];
        end else begin
          runlen[i]++;
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, expected run to complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [NO-1:0] m;
    repeat (4) @(negedge clk);
    // R9: held in reset, all parked
    expect_all('0, "R9");
    @(negedge clk) rst = 1'b0;
    settle();
    // R10: everything running
    expect_all('1, "R10");

    // R1 / R2: individual disables
    @(negedge clk) begin en_pci[2] = 0; en_66[5] = 0; en_cpu[1] = 0; end
    settle();
    m = '1; m[2] = 0; m[17] = 0; m[19] = 0; m[22] = 0;
    expect_all(m, "R1 R2");

    // R3 / R4: PCI stop with exempt bit 1 set to obey
    @(negedge clk) begin
      en_pci = '1; en_66 = '1; en_cpu = '1;
      pcif_stoppable = 3'b010; pci_stop_n = 0;
    end
    settle();
    m = '1; m[6:0] = '0; m[8] = 0;
    expect_all(m, "R3 R4");

    // R4 with all exempt bits 0: exempt clocks run during PCI stop
    @(negedge clk) pcif_stoppable = 3'b000;
    settle();
    m = '1; m[6:0] = '0;
    expect_all(m, "R4");

    // R5: CPU stop only
    @(negedge clk) begin pci_stop_n = 1; cpu_stop_n = 0; end
    settle();
    m = '1; m[23:18] = '0;
    expect_all(m, "R5");

    // R6: power-down
    @(negedge clk) pd_n = 0;
    settle();
    expect_all('0, "R6");

    // R8: release, everything resumes
    @(negedge clk) begin pd_n = 1; cpu_stop_n = 1; end
    settle();
    expect_all('1, "R8");

    // R7: random enable and stop traffic
    for (int r = 0; r < 60; r++) begin
      @(negedge clk);
      en_pci = 7'($urandom); en_pcif = 3'($urandom); pcif_stoppable = 3'($urandom);
      en_48 = 2'($urandom); en_66 = 6'($urandom); en_cpu = 3'($urandom);
      pd_n = ($urandom % 5) != 0; pci_stop_n = $urandom; cpu_stop_n = $urandom;
      repeat (1 + $urandom % 20) @(negedge clk);
    end

    @(negedge clk) begin
      en_pci = '1; en_pcif = '1; en_48 = '1; en_66 = '1; en_cpu = '1;
      pd_n = 1; pci_stop_n = 1; cpu_stop_n = 1;
    end
    settle();
    expect_all('1, "R8");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule